// File: doc/BRIEF.md
# Interrupt Priority Preemption Stack

This block keeps the running priority level of an interrupt controller and remembers earlier levels while interrupts nest. A pending request, already chosen by an arbiter elsewhere, comes in as a 4-bit priority with a valid flag. The block forwards it to the processor only when it outranks the running level. When the processor takes the interrupt, the running level is saved on a small hardware stack and replaced by the level of the request that preempted it. An end-of-interrupt write restores the saved level.

The take event has two possible sources, chosen by a mode input. One is a read of the acknowledge register by software. The other is an acknowledge strobe from the processor. Software can also overwrite the running level directly, raising or lowering it to build a priority-ceiling scheme, and the stack is not affected. The level is read back through a 32-bit register image. The stack reports when it is empty or full, and a sticky error flag records any push into a full stack and any pop from an empty one.

Top module: `irq_prio_stack`

## Requirements
- R1: After a synchronous active-low reset, `cur_prio` is 15 (4'b1111), the stack is empty, `stk_err` is 0 and `irq_out` is 0 whatever the request inputs are.
- R2: The level encoding is numeric: 15 is the highest and 0 is the lowest. `irq_out` is 1 in the same cycle exactly when `req_valid` is 1 and `req_prio` is strictly greater than `cur_prio`. An equal or lower request is masked.
- R3: `pri_rdata` carries `cur_prio` in bits [3:0]. Bits [31:4] always read 0.
- R4: With `hw_vec_mode`=0, a cycle with `sw_ack_rd`=1 pushes `cur_prio` onto the stack, and from the next edge `cur_prio` equals the `req_prio` of that cycle. `hw_ack` has no effect in this mode.
- R5: With `hw_vec_mode`=1, `hw_ack` performs the same push and load as R4, and `sw_ack_rd` has no effect.
- R6: A cycle with `eoi_wr`=1 and no take event pops the top entry into `cur_prio` at the next edge. Entries come back in reverse order of their pushes.
- R7: A cycle with `pri_wr`=1 and neither a take event nor `eoi_wr` loads `pri_wdata[3:0]` into `cur_prio` at the next edge and leaves the stack unchanged. `pri_wr` is ignored in any cycle that also has a take event or `eoi_wr`.
- R8: The stack holds 15 entries. `stk_empty` is 1 exactly when it holds 0 entries, and `stk_full` is 1 exactly when it holds 15.
- R9: A take event while the stack is full pushes nothing and leaves `cur_prio` unchanged. An `eoi_wr` while the stack is empty likewise changes nothing. Both cases set `stk_err`.
- R10: When `eoi_wr` and a take event fall in the same cycle, the pop is applied first and the push second. On a non-empty stack, `cur_prio` becomes `req_prio` and the depth stays the same. On an empty stack, the pop fails as in R9, then the old `cur_prio` is pushed and `cur_prio` becomes `req_prio`.
- R11: Once set, `stk_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A pending request is present |
| req_prio | input | 4 | Level of the pending request |
| hw_vec_mode | input | 1 | 1: the take event is `hw_ack`; 0: the take event is `sw_ack_rd` |
| sw_ack_rd | input | 1 | Acknowledge-register read strobe |
| hw_ack | input | 1 | Processor acknowledge strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| pri_wr | input | 1 | Direct write strobe for the level field |
| pri_wdata | input | 32 | Write data; only bits [3:0] are used |
| pri_rdata | output | 32 | Register image of the running level |
| cur_prio | output | 4 | Running level |
| irq_out | output | 1 | Masked interrupt request to the processor |
| stk_empty | output | 1 | Stack holds no entry |
| stk_full | output | 1 | Stack holds 15 entries |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions assume that every input is driven to a known 0 or 1 on each rising edge and held stable around it. They also assume that `hw_vec_mode` is sampled together with the strobes on the same edge, so the active take source is decided within a single cycle. The bench changes inputs only on the falling edge. It drives every strobe combination, including both take sources in both modes, simultaneous pop and push on empty, partly filled and full stacks, and direct writes that collide with stack events. Because any mix of inputs is legal for this block, the random phase draws freely, and it biases the strobe rates only to reach the full and empty states.

// File: rtl/irq_prio_pkg.sv
// Package irq_prio_pkg
// Shared widths and types for the interrupt priority preemption stack.
// Assumes the level width is the same everywhere in the block.
package irq_prio_pkg;
    localparam int PRIO_W = 4;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_TOP = '1;
endpackage

// File: rtl/prio_lifo.sv
// Module prio_lifo
// Last-in first-out store of saved priority levels. In one cycle a pop
// is resolved first and a push second, so a push may land in the slot
// that the pop has just freed. Requests that cannot be served are
// reported as refused; the caller decides what that means.
// Assumes: pop_req/push_req are single-cycle qualified strobes.
module prio_lifo
    import irq_prio_pkg::*;
#(
    parameter int DEPTH = 15,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pop_req,
    input  logic push_req,
    input  prio_t push_data,
    output prio_t top_data,
    output logic pop_ok,
    output logic push_ok,
    output logic empty,
    output logic full
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    prio_t            mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] after_pop;
    logic [CNT_W-1:0] rd_idx;

    // Resolve pop then push against the current fill level.
    always_comb begin
        pop_ok    = pop_req && (count != '0);
        after_pop = count - CNT_W'(pop_ok);
        push_ok   = push_req && (after_pop != CNT_MAX);
        rd_idx    = count - CNT_W'(1);
        top_data  = (count != '0) ? mem[rd_idx] : '0;
        empty     = (count == '0);
        full      = (count == CNT_MAX);
    end

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= after_pop + CNT_W'(push_ok);
    end

    // Write the pushed level into the slot above the post-pop top.
    always_ff @(posedge clk) begin
        if (push_ok) mem[after_pop] <= push_data;
    end
endmodule

// File: rtl/prio_event_ctrl.sv
// Module prio_event_ctrl
// Chooses the take source by mode and orders same-cycle events:
// pop, then push, then direct write only if no stack event is present.
// Produces the stack requests and the next running level.
// Assumes the stack answers pop_ok/push_ok combinationally.
module prio_event_ctrl
    import irq_prio_pkg::*;
(
    input  logic  hw_vec_mode,
    input  logic  sw_ack_rd,
    input  logic  hw_ack,
    input  logic  eoi_wr,
    input  logic  pri_wr,
    input  prio_t wr_prio,
    input  prio_t req_prio,
    input  prio_t cur,
    input  prio_t top_data,
    input  logic  pop_ok,
    input  logic  push_ok,
    output logic  pop_req,
    output logic  push_req,
    output prio_t push_data,
    output prio_t nxt,
    output logic  fault
);
    logic  take;
    prio_t restored;

    // Pick the take source and form the stack requests.
    always_comb begin
        take      = hw_vec_mode ? hw_ack : sw_ack_rd;
        pop_req   = eoi_wr;
        push_req  = take;
        restored  = pop_ok ? top_data : cur;
        push_data = restored;
    end

    // Next running level, in event order.
    always_comb begin
        if (take)        nxt = push_ok ? req_prio : restored;
        else if (eoi_wr) nxt = restored;
        else if (pri_wr) nxt = wr_prio;
        else             nxt = cur;
    end

    // Any refused stack request is a fault.
    always_comb fault = (eoi_wr && !pop_ok) || (take && !push_ok);
endmodule

// File: rtl/irq_prio_stack.sv
// Module irq_prio_stack (top)
// Holds the running interrupt level, masks the pending request against
// it, saves the level on a take event and restores it on end of
// interrupt. Also exposes a register image of the level.
// Assumes the pending request has already been arbitrated elsewhere.
module irq_prio_stack
    import irq_prio_pkg::*;
#(
    parameter int DEPTH = 15,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_prio,
    input  logic             hw_vec_mode,
    input  logic             sw_ack_rd,
    input  logic             hw_ack,
    input  logic             eoi_wr,
    input  logic             pri_wr,
    input  logic [REG_W-1:0] pri_wdata,
    output logic [REG_W-1:0] pri_rdata,
    output logic [3:0]       cur_prio,
    output logic             irq_out,
    output logic             stk_empty,
    output logic             stk_full,
    output logic             stk_err
);
    prio_t cur_q, nxt, top_data, push_data;
    logic  pop_req, push_req, pop_ok, push_ok, fault;

    prio_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_req  (pop_req),
        .push_req (push_req),
        .push_data(push_data),
        .top_data (top_data),
        .pop_ok   (pop_ok),
        .push_ok  (push_ok),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    prio_event_ctrl u_ctrl (
        .hw_vec_mode(hw_vec_mode),
        .sw_ack_rd  (sw_ack_rd),
        .hw_ack     (hw_ack),
        .eoi_wr     (eoi_wr),
        .pri_wr     (pri_wr),
        .wr_prio    (pri_wdata[PRIO_W-1:0]),
        .req_prio   (req_prio),
        .cur        (cur_q),
        .top_data   (top_data),
        .pop_ok     (pop_ok),
        .push_ok    (push_ok),
        .pop_req    (pop_req),
        .push_req   (push_req),
        .push_data  (push_data),
        .nxt        (nxt),
        .fault      (fault)
    );

    // Running level register, highest level out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= PRIO_TOP;
        else        cur_q <= nxt;
    end

    // Sticky stack error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     stk_err <= 1'b0;
        else if (fault) stk_err <= 1'b1;
    end

    // Mask the pending request against the running level.
    always_comb irq_out = req_valid && (req_prio > cur_q);

    // Register image: level in the low bits, zero above.
    always_comb begin
        pri_rdata               = '0;
        pri_rdata[PRIO_W-1:0]   = cur_q;
        cur_prio                = cur_q;
    end
endmodule

// File: rtl/irq_prio_stack_chk.sv
// Module irq_prio_stack_chk
// Temporal checks on the priority stack ports, attached by bind.
// Assumes inputs are known and stable at each rising edge.
module irq_prio_stack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [3:0]  req_prio,
    input logic        hw_vec_mode,
    input logic        sw_ack_rd,
    input logic        hw_ack,
    input logic        eoi_wr,
    input logic        pri_wr,
    input logic [31:0] pri_wdata,
    input logic [3:0]  cur_prio,
    input logic        irq_out,
    input logic        stk_empty,
    input logic        stk_full,
    input logic        stk_err
);
    logic take;
    always_comb take = hw_vec_mode ? hw_ack : sw_ack_rd;

    // R2: no request, or top running level, never raises the line
    a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || cur_prio == 4'hF) |-> !irq_out);

    // R4/R5: a served take loads the request level and leaves the stack non-empty
    a_r4_take_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !eoi_wr && !stk_full) |=> (cur_prio == $past(req_prio)) && !stk_empty);

    // R7: a lone direct write lands at the next edge
    a_r7_direct_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_wr && !take && !eoi_wr) |=> cur_prio == $past(pri_wdata[3:0]));

    // R8: the stack cannot be empty and full at once
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_empty && stk_full));

    // R9: a pop from an empty stack flags an error and keeps the level
    a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !take && stk_empty) |=> stk_err && $stable(cur_prio));

    // R9: a take into a full stack flags an error and keeps the level
    a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !eoi_wr && stk_full) |=> stk_err && $stable(cur_prio) && stk_full);

    // R11: the error flag never clears without reset
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);
endmodule

bind irq_prio_stack irq_prio_stack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_prio   (req_prio),
    .hw_vec_mode(hw_vec_mode),
    .sw_ack_rd  (sw_ack_rd),
    .hw_ack     (hw_ack),
    .eoi_wr     (eoi_wr),
    .pri_wr     (pri_wr),
    .pri_wdata  (pri_wdata),
    .cur_prio   (cur_prio),
    .irq_out    (irq_out),
    .stk_empty  (stk_empty),
    .stk_full   (stk_full),
    .stk_err    (stk_err)
);

// File: tb/irq_prio_stack_tb.sv
// Bench for irq_prio_stack: behavioural queue model compared every cycle.
module irq_prio_stack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_prio = '0;
    logic        hw_vec_mode = 1'b0;
    logic        sw_ack_rd = 1'b0;
    logic        hw_ack = 1'b0;
    logic        eoi_wr = 1'b0;
    logic        pri_wr = 1'b0;
    logic [31:0] pri_wdata = '0;
    logic [31:0] pri_rdata;
    logic [3:0]  cur_prio;
    logic        irq_out, stk_empty, stk_full, stk_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // model state
    int m_stk[$];
    int m_cur = 15;
    bit m_err = 1'b0;

    always #5 clk = ~clk;

    irq_prio_stack u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
        .hw_vec_mode(hw_vec_mode), .sw_ack_rd(sw_ack_rd), .hw_ack(hw_ack),
        .eoi_wr(eoi_wr), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
        .pri_rdata(pri_rdata), .cur_prio(cur_prio), .irq_out(irq_out),
        .stk_empty(stk_empty), .stk_full(stk_full), .stk_err(stk_err)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model (called mid-cycle).
    task automatic compare(input string tag);
        int exp_irq;
        exp_irq = (req_valid && (int'(req_prio) > m_cur)) ? 1 : 0;
        check("R2", "irq_out", irq_out, exp_irq);
        check(tag, "cur_prio", cur_prio, m_cur);
        check("R3", "pri_rdata", pri_rdata, m_cur);
        check("R8", "stk_empty", stk_empty, (m_stk.size() == 0) ? 1 : 0);
        check("R8", "stk_full", stk_full, (m_stk.size() == 15) ? 1 : 0);
        check("R9/R11", "stk_err", stk_err, m_err);
    endtask

    // Advance the model by one edge using the inputs held this cycle.
    task automatic model_edge();
        bit take, pop_ok;
        int restored, nxt;
        take = hw_vec_mode ? hw_ack : sw_ack_rd;
        pop_ok = eoi_wr && (m_stk.size() > 0);
        if (eoi_wr && !pop_ok) m_err = 1'b1;
        restored = pop_ok ? m_stk.pop_back() : m_cur;
        if (take) begin
            if (m_stk.size() < 15) begin
                m_stk.push_back(restored);
                nxt = int'(req_prio);
            end else begin
                m_err = 1'b1;
                nxt = restored;
            end
        end else if (eoi_wr) nxt = restored;
        else if (pri_wr)     nxt = int'(pri_wdata[3:0]);
        else                 nxt = m_cur;
        m_cur = nxt;
    endtask

    // One cycle: drive at negedge, compare, clock, update model.
    task automatic step(input string tag, input bit mode, input bit sw, input bit hw,
                        input bit eoi, input bit wr, input logic [31:0] wd,
                        input bit rv, input logic [3:0] rp);
        hw_vec_mode = mode; sw_ack_rd = sw; hw_ack = hw; eoi_wr = eoi;
        pri_wr = wr; pri_wdata = wd; req_valid = rv; req_prio = rp;
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input bit mode);
        step(tag, mode, 0, 0, 0, 0, 32'h0, 1, 4'hF);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sw_ack_rd = 0; hw_ack = 0; eoi_wr = 0; pri_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_stk.delete(); m_cur = 15; m_err = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state, with a high request present
        step("R1", 0, 0, 0, 0, 0, 32'h0, 1, 4'hF);
        check("R1", "cur_prio after reset", cur_prio, 15);

        // R2: mask sweep against level 5, valid and not valid
        step("R7", 0, 0, 0, 0, 1, 32'hABCD_EF05, 0, 4'h0);
        for (int p = 0; p < 16; p++) begin
            step("R2", 0, 0, 0, 0, 0, 32'h0, 1, 4'(p));
            step("R2", 0, 0, 0, 0, 0, 32'h0, 0, 4'(p));
        end

        // R4: software mode; hw_ack ignored, then fill with reads
        step("R4", 0, 0, 1, 0, 0, 32'h0, 1, 4'h9);
        idle("R4", 0);
        for (int i = 0; i < 15; i++) step("R4", 0, 1, 0, 0, 0, 32'h0, 1, 4'(i));
        idle("R8", 0);
        // R9: overflow
        step("R9", 0, 1, 0, 0, 0, 32'h0, 1, 4'hE);
        idle("R9", 0);
        // R6: unwind in reverse order
        for (int i = 0; i < 15; i++) step("R6", 0, 0, 0, 1, 0, 32'h0, 1, 4'h3);
        // R9: underflow, then R11 stickiness
        step("R9", 0, 0, 0, 1, 0, 32'h0, 1, 4'h3);
        for (int i = 0; i < 4; i++) idle("R11", 0);

        do_reset();
        // R5: hardware mode; sw read ignored, strobe pushes
        step("R5", 1, 1, 0, 0, 0, 32'h0, 1, 4'h6);
        idle("R5", 1);
        step("R7", 1, 0, 0, 0, 1, 32'h0000_0002, 1, 4'h0);
        step("R5", 1, 0, 1, 0, 0, 32'h0, 1, 4'h7);
        step("R5", 1, 0, 1, 0, 0, 32'h0, 1, 4'hB);
        idle("R5", 1);
        // R10: simultaneous pop and push on a non-empty stack
        step("R10", 1, 0, 1, 1, 0, 32'h0, 1, 4'hD);
        idle("R10", 1);
        step("R6", 1, 0, 0, 1, 0, 32'h0, 1, 4'h0);
        step("R6", 1, 0, 0, 1, 0, 32'h0, 1, 4'h0);
        idle("R8", 1);
        // R10: simultaneous on empty stack
        step("R10", 1, 0, 1, 1, 0, 32'h0, 1, 4'hC);
        idle("R10", 1);
        // R7: direct write ignored beside take and beside eoi
        step("R7", 1, 0, 1, 0, 1, 32'h0000_0001, 1, 4'hE);
        step("R7", 1, 0, 0, 1, 1, 32'h0000_0004, 1, 4'h0);
        step("R7", 1, 0, 0, 0, 1, 32'hFFFF_FFF8, 1, 4'h0);
        idle("R7", 1);

        // Random phase with biased strobes
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            automatic int ph = (i / 500) % 2;
            automatic bit sw = ($urandom_range(99) < (ph ? 15 : 45));
            automatic bit hw = ($urandom_range(99) < (ph ? 15 : 45));
            automatic bit eo = ($urandom_range(99) < (ph ? 45 : 15));
            automatic bit wr = ($urandom_range(99) < 10);
            step("R10", bit'($urandom_range(1)), sw, hw, eo, wr, $urandom,
                 bit'($urandom_range(1)), 4'($urandom_range(15)));
            if (i % 1000 == 999) do_reset();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule